// File: doc/BRIEF.md
# Serial Radix-2 Add-Compare-Select Unit

This block performs the add-compare-select recursion of a Viterbi decoder for a sixteen-state trellis (constraint length 5). It keeps one path metric per trellis state. A trellis stage is fed as a short series of beats. Each beat carries the branch metrics for two radix-2 butterflies. Butterfly `j` joins source states `j` and `j+8` to destination states `2j` and `2j+1`. Each butterfly forms four candidate sums, one per transition. For each destination it keeps the cheaper of its two candidates and records which source won.

With the default parameters a stage takes four accepted beats. After the last beat the block commits all sixteen new metrics at once. It presents the sixteen decision bits and raises a one-cycle completion pulse. A later survivor or traceback stage consumes those bits. The metrics stay bounded through a shared-MSB normalization that needs no subtractor.

Top module: `acs_butterfly_serial`

## Requirements
- R1: While reset is asserted and on release, state 0 holds metric 0, every other state holds 2^(PM_W-2) (256 by default), `dec_out` is all zero and `stage_done` is low.
- R2: Beat number c (0 to 3) of a stage, lane b (0 or 1), serves butterfly j = 2c+b. Its four branch metrics sit in `bm_in[(4b+t)*BM_W +: BM_W]`, where t=0 is j->2j, t=1 is j+8->2j, t=2 is j->2j+1 and t=3 is j+8->2j+1.
- R3: The new metric of each destination equals the smaller of its two candidates. A candidate is the source state's metric plus the branch metric of that transition.
- R4: The decision bit of destination d is 1 when the survivor comes from the upper source (j+8) and 0 when it comes from source j. On equal candidates the bit is 0.
- R5: `stage_done` is high for exactly one cycle, in the cycle after the fourth accepted beat. `pm_out` and `dec_out` take their new values in that same cycle and hold them at all other times.
- R6: If all sixteen new metrics have bit PM_W-1 set, that bit is cleared in every one of them before they are stored.
- R7: A cycle with `bm_valid` low is ignored. It does not advance the beat position and it changes no output.
- R8: Asserting reset part-way through a stage discards the beats taken so far. The next stage starts again at beat 0 from the reset metrics.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bm_valid | input | 1 | `bm_in` carries one beat of branch metrics |
| bm_in | input | 2*4*BM_W | Unsigned branch metrics for two butterflies, layout per R2 |
| pm_out | output | 16*PM_W | Committed metric of state s at `[s*PM_W +: PM_W]` |
| dec_out | output | 16 | Decision bit of destination state s at bit s |
| stage_done | output | 1 | One-cycle pulse when a stage's metrics and decisions are committed |

## Verification
The bench builds the block with its defaults: PM_W=10, BM_W=6, constraint length 5 and two lanes. This gives a four-beat stage and a branch metric of at most 63. With those values a run of stages where every branch costs 63 lifts all metrics past 512 within nine stages. That brings the normalization event into a short run. An all-zero stage from reset produces ties between equal 256 metrics, which exercises the tie rule. Table-driven stages with distinct metrics in every field exercise the field layout and the choice of the upper source.

// File: rtl/acs_butterfly_serial.sv
module acs_butterfly_serial #(
  parameter int PM_W  = 10,
  parameter int BM_W  = 6,
  parameter int K     = 5,
  parameter int LANES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bm_valid,
  input  logic [LANES*4*BM_W-1:0]    bm_in,
  output logic [(1<<(K-1))*PM_W-1:0] pm_out,
  output logic [(1<<(K-1))-1:0]      dec_out,
  output logic                       stage_done
);

  localparam int NS    = 1 << (K-1);
  localparam int HALF  = NS / 2;
  localparam int BEATS = HALF / LANES;
  localparam int CW    = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int SW    = $clog2(NS);
  localparam logic [PM_W-1:0] INIT_BIG = PM_W'(1) << (PM_W-2);

  logic [PM_W-1:0] pm_q    [NS];
  logic [PM_W-1:0] stage_q [NS];
  logic [PM_W-1:0] merged  [NS];
  logic [PM_W-1:0] normed  [NS];
  logic [NS-1:0]   dec_acc, merged_dec, dec_q;
  logic [CW-1:0]   beat_q;
  logic            done_q, all_msb;

  logic [SW-2:0]   lane_j  [LANES];
  logic [PM_W-1:0] lane_pe [LANES];
  logic [PM_W-1:0] lane_po [LANES];
  logic            lane_de [LANES];
  logic            lane_do [LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [PM_W-1:0] src_lo, src_hi, bm0, bm1, bm2, bm3;
    logic [PM_W-1:0] c_lo_e, c_hi_e, c_lo_o, c_hi_o;
    assign lane_j[l] = (SW-1)'(int'(beat_q) * LANES + l);
    assign src_lo = pm_q[{1'b0, lane_j[l]}];
    assign src_hi = pm_q[{1'b1, lane_j[l]}];
    assign bm0 = PM_W'(bm_in[(l*4+0)*BM_W +: BM_W]);
    assign bm1 = PM_W'(bm_in[(l*4+1)*BM_W +: BM_W]);
    assign bm2 = PM_W'(bm_in[(l*4+2)*BM_W +: BM_W]);
    assign bm3 = PM_W'(bm_in[(l*4+3)*BM_W +: BM_W]);
    assign c_lo_e = src_lo + bm0;
    assign c_hi_e = src_hi + bm1;
    assign c_lo_o = src_lo + bm2;
    assign c_hi_o = src_hi + bm3;
    assign lane_de[l] = c_hi_e < c_lo_e;
    assign lane_do[l] = c_hi_o < c_lo_o;
    assign lane_pe[l] = lane_de[l] ? c_hi_e : c_lo_e;
    assign lane_po[l] = lane_do[l] ? c_hi_o : c_lo_o;
  end

  always_comb begin
    merged     = stage_q;
    merged_dec = dec_acc;
    for (int l = 0; l < LANES; l++) begin
      merged[{lane_j[l], 1'b0}]     = lane_pe[l];
      merged[{lane_j[l], 1'b1}]     = lane_po[l];
      merged_dec[{lane_j[l], 1'b0}] = lane_de[l];
      merged_dec[{lane_j[l], 1'b1}] = lane_do[l];
    end
    all_msb = 1'b1;
    for (int s = 0; s < NS; s++) all_msb = all_msb & merged[s][PM_W-1];
    for (int s = 0; s < NS; s++) begin
      normed[s] = merged[s];
      if (all_msb) normed[s][PM_W-1] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NS; s++) begin
        pm_q[s]    <= (s == 0) ? '0 : INIT_BIG;
        stage_q[s] <= '0;
      end
      dec_acc <= '0;
      dec_q   <= '0;
      beat_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (bm_valid) begin
        stage_q <= merged;
        dec_acc <= merged_dec;
        if (int'(beat_q) == BEATS-1) begin
          beat_q <= '0;
          pm_q   <= normed;
          dec_q  <= merged_dec;
          done_q <= 1'b1;
        end else begin
          beat_q <= beat_q + 1'b1;
        end
      end
    end
  end

  for (genvar s = 0; s < NS; s++) begin : g_out
    assign pm_out[s*PM_W +: PM_W] = pm_q[s];
  end
  assign dec_out    = dec_q;
  assign stage_done = done_q;

  logic [NS-1:0] out_msb;
  for (genvar s = 0; s < NS; s++) begin : g_msb
    assign out_msb[s] = pm_out[s*PM_W + PM_W-1];
  end

  p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stage_done |=> !stage_done);
  p_hold_outputs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !stage_done |-> ($stable(pm_out) && $stable(dec_out)));
  p_norm_applied_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stage_done |-> !(&out_msb));
  p_idle_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bm_valid |=> ($stable(beat_q) && !stage_done));
  p_done_after_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stage_done |-> ($past(bm_valid) && int'($past(beat_q)) == BEATS-1));

endmodule

// File: tb/acs_butterfly_serial_tb.sv
module acs_butterfly_serial_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PM_W = 10;
  localparam int BM_W = 6;
  localparam int NS = 16;
  localparam int BW = 2*4*BM_W;

  localparam logic [BW-1:0] VEC [16] = '{
    48'h3A1C_05F2_9B47, 48'h0F0F_F0F0_1234, 48'h7E81_4C2D_A965, 48'h0001_0203_0405,
    48'hFFC0_003F_F00F, 48'h5A5A_A5A5_3C3C, 48'h1111_2222_4444, 48'h8421_0842_1084,
    48'hC3B2_A190_8F7E, 48'h0000_0FFF_FFF0, 48'h2468_ACE0_1357, 48'h9BDF_0246_8ACE,
    48'h6D5C_4B3A_2918, 48'hE7D6_C5B4_A392, 48'h0A0B_0C0D_0E0F, 48'hF1E2_D3C4_B5A6
  };

  logic clk = 0;
  logic rst_n = 0;
  logic bm_valid = 0;
  logic [BW-1:0] bm_in = '0;
  logic [NS*PM_W-1:0] pm_out;
  logic [NS-1:0] dec_out;
  logic stage_done;

  int nvec = 0, nfail = 0, norm_events = 0;
  int mpm [NS];
  logic [NS-1:0] mdec;

  always #(CLK_PERIOD/2) clk = ~clk;

  acs_butterfly_serial dut_i (
    .clk(clk), .rst_n(rst_n), .bm_valid(bm_valid), .bm_in(bm_in),
    .pm_out(pm_out), .dec_out(dec_out), .stage_done(stage_done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_outputs(input string tag);
    for (int s = 0; s < NS; s++) chk({tag, " pm"}, int'(pm_out[s*PM_W +: PM_W]), mpm[s]);
    chk({tag, " dec"}, int'(dec_out), int'(mdec));
  endtask

  task automatic model_reset();
    for (int s = 0; s < NS; s++) mpm[s] = (s == 0) ? 0 : 256;
    mdec = '0;
  endtask

  task automatic model_stage(input logic [BW-1:0] b [4]);
    int nw [NS];
    bit all_hi;
    for (int j = 0; j < 8; j++) begin
      int a, h;
      logic [BW-1:0] bt;
      bt = b[j/2];
      a = mpm[j]   + int'(bt[((j%2)*4+0)*BM_W +: BM_W]);
      h = mpm[j+8] + int'(bt[((j%2)*4+1)*BM_W +: BM_W]);
      nw[2*j] = (h < a) ? h : a;  mdec[2*j] = (h < a);
      a = mpm[j]   + int'(bt[((j%2)*4+2)*BM_W +: BM_W]);
      h = mpm[j+8] + int'(bt[((j%2)*4+3)*BM_W +: BM_W]);
      nw[2*j+1] = (h < a) ? h : a;  mdec[2*j+1] = (h < a);
    end
    all_hi = 1;
    for (int s = 0; s < NS; s++) if (nw[s] < 512) all_hi = 0;
    if (all_hi) norm_events++;
    for (int s = 0; s < NS; s++) mpm[s] = all_hi ? nw[s] - 512 : nw[s];
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; bm_valid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  task automatic run_stage(input logic [BW-1:0] b [4], input int gap, input string tag);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      if (c > 0) chk({tag, " R5 no pulse mid-stage"}, int'(stage_done), 0);
      bm_valid = 1; bm_in = b[c];
      for (int g = 0; g < gap && c < 3; g++) begin
        @(negedge clk);
        bm_valid = 0; bm_in = ~b[c];
        chk({tag, " R7 idle no pulse"}, int'(stage_done), 0);
        chk({tag, " R7 idle pm0 held"}, int'(pm_out[0 +: PM_W]), mpm[0]);
        chk({tag, " R7 idle pm15 held"}, int'(pm_out[15*PM_W +: PM_W]), mpm[15]);
      end
    end
    @(negedge clk);
    bm_valid = 0;
    model_stage(b);
    chk({tag, " R5 pulse"}, int'(stage_done), 1);
    chk_outputs({tag, " R3 R4"});
    @(negedge clk);
    chk({tag, " R5 pulse single"}, int'(stage_done), 0);
    chk_outputs({tag, " R5 held"});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL R5 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [BW-1:0] b [4];
    model_reset();
    repeat (2) @(negedge clk);
    chk_outputs("R1 in reset");
    chk("R1 done low", int'(stage_done), 0);
    do_reset();
    chk_outputs("R1 after release");

    // R4 ties: all-zero branch metrics from reset
    for (int c = 0; c < 4; c++) b[c] = '0;
    run_stage(b, 0, "R4 tie");
    chk("R4 tie decisions zero", int'(dec_out), 0);

    // R2 R3 table of stages
    for (int st = 0; st < 4; st++) begin
      for (int c = 0; c < 4; c++) b[c] = VEC[st*4+c];
      run_stage(b, 0, "R2 table");
    end

    // R7 gaps between beats
    for (int c = 0; c < 4; c++) b[c] = VEC[15-c];
    run_stage(b, 2, "R7 gaps");

    // R8 reset mid-stage
    @(negedge clk); bm_valid = 1; bm_in = VEC[3];
    @(negedge clk); bm_in = VEC[4];
    do_reset();
    chk_outputs("R8 reset state");
    for (int c = 0; c < 4; c++) b[c] = VEC[8+c];
    run_stage(b, 0, "R8 fresh stage");

    // R6 normalization: every branch costs 63
    do_reset();
    for (int c = 0; c < 4; c++) b[c] = '1;
    for (int st = 0; st < 10; st++) run_stage(b, 0, "R6 norm");
    chk("R6 normalization reached", norm_events, 1);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule